// File: doc/BRIEF.md
# Board Interrupt Aggregator with Card-Detect

This block gathers sixteen level-sensitive interrupt lines from board peripherals into one interrupt line for the host processor. Each line is sampled on every clock edge. When a line is high and its enable bit is set, its pending flag is captured. The host sees an interrupt whenever an enabled flag is pending. Software reads and rewrites the enable and pending words over a simple 32-bit register bus, with address, write enable, write data and a combinational read-data path. Software clears flags by writing the pending word directly.

Two of the interrupt lines also report card presence for two card slots. Each slot has a status word. Its low five bits are software-owned power and reset controls. Bit 5 is an active-low "no card" flag that follows the slot's detect line. A set of plain scratch words holds software-defined LED and control settings.

Top module: `board_irq_hub`

## Requirements
- R1: After reset, the enable word (0xC0), the pending word (0xD0) and all scratch words read 0, `host_irq` is low, and each slot status word reads 0x0000_0420 (bit 10 ready, bit 5 no-card).
- R2: At a clock edge where `irq_in[n]` is high and enable bit n is set, pending bit n becomes 1. A high line with its enable bit clear sets nothing. A pending bit is never cleared by its line falling, and is only cleared by a write to 0xD0.
- R3: A write to 0xC0 or 0xD0 stores only the bits in 0x000F_EEFF (bits 0-7, 9-11 and 13-19). All other bits are stored as 0.
- R4: `host_irq` is high exactly when the AND of the pending and enable words is nonzero. It reflects a register write from the cycle after that write's edge.
- R5: If a write to 0xD0 and a capture event for the same bit fall on the same edge, the bit ends at 1.
- R6: Slot 0 status (0xE0) bit 5 equals the inverse of `irq_in[9]` as sampled at the latest edge. Slot 1 status (0xE4) bit 5 does the same with `irq_in[13]`.
- R7: A write to a slot status word changes only bits [4:0]. Bits [31:6] keep their value, and bit 5 follows its detect line.
- R8: Scratch words at 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 each read back the last value written to them.
- R9: A read from any other offset returns 0, and a write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 16 | Level interrupt lines; line 9 and line 13 are slot detects |
| host_irq | output | 1 | Combined interrupt to the host |

## Verification
A software write to the pending word and a hardware capture can fall on the same edge and target the same bit. A detect-line update and a software write to the same slot status word can also coincide. The bench provokes both on purpose: it holds an enabled line high while clearing the pending word, and it toggles a detect line on the cycle a slot word is written. A behavioural model gives capture precedence, and merges the slot's control bits with the detect bit. The model is compared with the read data and `host_irq` on every clock, so any wrong priority shows up at once.

// File: rtl/bih_pkg.sv
package bih_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int NUM_IRQ   = 16;
    localparam int SCRATCH_N = 8;

    localparam logic [31:0] IRQ_LEGAL = 32'h000F_EEFF;

    localparam int OFF_MASK  = 'hC0;
    localparam int OFF_PEND  = 'hD0;
    localparam int OFF_SLOT0 = 'hE0;
    localparam int OFF_SLOT1 = 'hE4;

    localparam int CD_LINE0  = 9;
    localparam int CD_LINE1  = 13;

    localparam logic [31:0] SLOT_RST = 32'h0000_0420;

    function automatic int scratch_off(input int idx);
        case (idx)
            0:       return 'h10;
            1:       return 'h14;
            2:       return 'h40;
            3:       return 'h60;
            4:       return 'h80;
            5:       return 'h84;
            6:       return 'h88;
            default: return 'h90;
        endcase
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] en;
        logic [DATA_W-1:0] pend;
    } irq_state_t;

endpackage

// File: rtl/bih_irq_core.sv
module bih_irq_core
    import bih_pkg::*;
#(
    parameter int NUM_IN = NUM_IRQ,
    parameter int W      = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] lines,
    input  logic              wr_en_word,
    input  logic              wr_pend_word,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      en_o,
    output logic [W-1:0]      pend_o,
    output logic              irq_o
);

    irq_state_t state_d, state_q;
    logic [W-1:0] capture;
    logic [W-1:0] base;

    always_comb begin
        state_d = state_q;
        capture = W'(lines & state_q.en[NUM_IN-1:0]);
        base    = wr_pend_word ? (wdata & IRQ_LEGAL[W-1:0]) : state_q.pend;
        if (wr_en_word) begin
            state_d.en = wdata & IRQ_LEGAL[W-1:0];
        end
        state_d.pend = base | capture;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en_o   = state_q.en;
    assign pend_o = state_q.pend;
    assign irq_o  = |(state_q.pend & state_q.en);

    // enabled high line is captured on the next edge
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lines & en_o[NUM_IN-1:0])) |=>
        ((pend_o[NUM_IN-1:0] & $past(lines & en_o[NUM_IN-1:0])) == $past(lines & en_o[NUM_IN-1:0])));

    // without a pending-word write no flag drops
    assert_nodrop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend_word |=> (($past(pend_o) & ~pend_o) == '0));

    // same-edge capture beats the clearing write
    assert_capwins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend_word && (|(lines & en_o[NUM_IN-1:0]))) |=>
        ((pend_o[NUM_IN-1:0] & $past(lines & en_o[NUM_IN-1:0])) == $past(lines & en_o[NUM_IN-1:0])));

    // interrupt falls only after a register write
    assert_irqfall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(wr_en_word || wr_pend_word));

endmodule

// File: rtl/bih_slot_stat.sv
module bih_slot_stat
    import bih_pkg::*;
#(
    parameter int          W       = DATA_W,
    parameter logic [31:0] RST_VAL = SLOT_RST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         detect,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat_o
);

    localparam int CTRL_W  = 5;
    localparam int NCD_BIT = 5;

    logic [W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (wr) begin
            stat_d[CTRL_W-1:0] = wdata[CTRL_W-1:0];
        end
        stat_d[NCD_BIT] = ~detect;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= RST_VAL[W-1:0];
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;

    assert_ncd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_o[NCD_BIT] == !$past(detect)));

    assert_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(stat_o[W-1:NCD_BIT+1]));

    assert_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(stat_o[CTRL_W-1:0]));

endmodule

// File: rtl/bih_scratch.sv
module bih_scratch
    import bih_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W,
    parameter int N  = SCRATCH_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic          hit_o,
    output logic [W-1:0]  rdata_o
);

    logic [N-1:0]  sel;
    logic [W-1:0]  regs_d [N];
    logic [W-1:0]  regs_q [N];

    for (genvar i = 0; i < N; i++) begin : g_word
        assign sel[i] = (addr == AW'(scratch_off(i)));

        always_comb begin
            regs_d[i] = regs_q[i];
            if (we && sel[i]) begin
                regs_d[i] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end

        // an unselected word keeps its value
        assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel[i]) |=> $stable(regs_q[i]));
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) begin
                rdata_o = regs_q[i];
            end
        end
    end

    assign hit_o = |sel;

endmodule

// File: rtl/board_irq_hub.sv
module board_irq_hub
    import bih_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int AW     = ADDR_W,
    parameter int NUM_IN = NUM_IRQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              host_irq
);

    localparam int NSLOT = 2;

    logic sel_en, sel_pend;
    logic [NSLOT-1:0] sel_slot;
    logic [NSLOT-1:0] slot_det;
    logic [W-1:0] en_w, pend_w, scr_rd;
    logic [W-1:0] slot_w [NSLOT];
    logic scr_hit;

    assign sel_en      = (bus_addr == AW'(OFF_MASK));
    assign sel_pend    = (bus_addr == AW'(OFF_PEND));
    assign sel_slot[0] = (bus_addr == AW'(OFF_SLOT0));
    assign sel_slot[1] = (bus_addr == AW'(OFF_SLOT1));
    assign slot_det[0] = irq_in[CD_LINE0];
    assign slot_det[1] = irq_in[CD_LINE1];

    bih_irq_core #(.NUM_IN(NUM_IN), .W(W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .lines        (irq_in),
        .wr_en_word   (bus_we && sel_en),
        .wr_pend_word (bus_we && sel_pend),
        .wdata        (bus_wdata),
        .en_o         (en_w),
        .pend_o       (pend_w),
        .irq_o        (host_irq)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        bih_slot_stat #(.W(W), .RST_VAL(SLOT_RST)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .detect (slot_det[s]),
            .wr     (bus_we && sel_slot[s]),
            .wdata  (bus_wdata),
            .stat_o (slot_w[s])
        );
    end

    bih_scratch #(.W(W), .AW(AW), .N(SCRATCH_N)) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .hit_o   (scr_hit),
        .rdata_o (scr_rd)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_en)           bus_rdata = en_w;
        else if (sel_pend)    bus_rdata = pend_w;
        else if (sel_slot[0]) bus_rdata = slot_w[0];
        else if (sel_slot[1]) bus_rdata = slot_w[1];
        else if (scr_hit)     bus_rdata = scr_rd;
    end

endmodule

// File: tb/sim_board_irq_hub.sv
module sim_board_irq_hub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        host_irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_en, m_pend, m_s0, m_s1;
    logic [31:0] m_scr [int];

    board_irq_hub u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .host_irq(host_irq)
    );

    always #5 clk = ~clk;

    function automatic bit is_scr(input int a);
        return a == 'h10 || a == 'h14 || a == 'h40 || a == 'h60 ||
               a == 'h80 || a == 'h84 || a == 'h88 || a == 'h90;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        if (a == 'hC0) return m_en;
        if (a == 'hD0) return m_pend;
        if (a == 'hE0) return m_s0;
        if (a == 'hE4) return m_s1;
        if (is_scr(a)) return m_scr.exists(a) ? m_scr[a] : 32'h0;
        return 32'h0;
    endfunction

    function automatic string tag_of(input int a);
        if (a == 'hC0) return "R3";
        if (a == 'hD0) return "R2";
        if (a == 'hE0 || a == 'hE4) return "R6";
        if (is_scr(a)) return "R8";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h (addr %h, t=%0t)", tag, act, exp, bus_addr, $time);
        end
    endtask

    // model update on each edge, from inputs that are stable there
    always @(posedge clk) begin
        logic [31:0] cap;
        logic [31:0] base;
        if (!rst_n) begin
            m_en = 0; m_pend = 0; m_s0 = 32'h420; m_s1 = 32'h420;
            m_scr.delete();
        end else begin
            cap  = {16'h0, irq_in} & m_en;
            base = m_pend;
            if (bus_we) begin
                case (int'(bus_addr))
                    'hC0: m_en = bus_wdata & 32'h000F_EEFF;
                    'hD0: base = bus_wdata & 32'h000F_EEFF;
                    'hE0: m_s0 = {m_s0[31:5], bus_wdata[4:0]};
                    'hE4: m_s1 = {m_s1[31:5], bus_wdata[4:0]};
                    default: if (is_scr(int'(bus_addr))) m_scr[int'(bus_addr)] = bus_wdata;
                endcase
            end
            m_pend = base | cap;
            m_s0[5] = ~irq_in[9];
            m_s1[5] = ~irq_in[13];
        end
    end

    // compare on every clock, after the edge settles
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            check(tag_of(int'(bus_addr)), bus_rdata, m_read(int'(bus_addr)));
            check("R4", {31'h0, host_irq}, {31'h0, |(m_pend & m_en)});
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = 8'(a);
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd('hC0, 0, "R1"); rd('hD0, 0, "R1"); rd('h10, 0, "R1"); rd('h90, 0, "R1");
        rd('hE0, 32'h420, "R1"); rd('hE4, 32'h420, "R1");
        check("R1", {31'h0, host_irq}, 0);

        // R3 legal filter
        wr('hC0, 32'hFFFF_FFFF); rd('hC0, 32'h000F_EEFF, "R3");
        wr('hD0, 32'hFFFF_FFFF); rd('hD0, 32'h000F_EEFF, "R3");
        check("R4", {31'h0, host_irq}, 1);
        wr('hD0, 0); rd('hD0, 0, "R3");
        check("R4", {31'h0, host_irq}, 0);

        // R2 capture only with enable, no clear on fall
        wr('hC0, 32'h0000_0008);
        @(negedge clk); irq_in = 16'h0014;
        @(negedge clk); irq_in = 16'h0000;
        rd('hD0, 0, "R2");
        @(negedge clk); irq_in = 16'h0008;
        @(negedge clk); irq_in = 16'h0000;
        rd('hD0, 32'h8, "R2");
        check("R4", {31'h0, host_irq}, 1);

        // R5 capture wins over same-edge clear
        @(negedge clk); irq_in = 16'h0008;
        wr('hD0, 0);
        irq_in = 16'h0000;
        rd('hD0, 32'h8, "R5");
        wr('hD0, 0); rd('hD0, 0, "R5");

        // R6 and R7 detect plus control write in the same cycle
        @(negedge clk); irq_in = 16'h0200;
        wr('hE0, 32'hFFFF_FFFF);
        rd('hE0, 32'h0000_041F, "R7");
        @(negedge clk); irq_in = 16'h2000;
        rd('hE0, 32'h0000_043F, "R6");
        rd('hE4, 32'h0000_0400, "R6");
        wr('hE4, 32'h0000_0015); rd('hE4, 32'h0000_0415, "R7");
        @(negedge clk); irq_in = 16'h0000;

        // R8 scratch words, R9 unmapped
        for (int i = 0; i < 8; i++) begin
            int offs [8] = '{'h10, 'h14, 'h40, 'h60, 'h80, 'h84, 'h88, 'h90};
            wr(offs[i], 32'hA5A5_0000 + 32'(i));
        end
        rd('h40, 32'hA5A5_0002, "R8"); rd('h90, 32'hA5A5_0007, "R8");
        wr('h44, 32'hDEAD_BEEF); rd('h44, 0, "R9"); rd('h40, 32'hA5A5_0002, "R9");

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int pick [14] = '{'hC0, 'hD0, 'hD0, 'hE0, 'hE4, 'h10, 'h14, 'h40,
                              'h60, 'h88, 'h90, 'h44, 'h00, 'hFC};
            @(negedge clk);
            bus_addr  = 8'(pick[$urandom_range(13)]);
            bus_we    = ($urandom_range(3) == 0);
            bus_wdata = $urandom;
            irq_in    = 16'($urandom) & 16'($urandom);
        end
        @(negedge clk); bus_we = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule